// File: doc/BRIEF.md
# Counter Enable Set/Clear Register Bank

This block keeps one enable bit for each counter in a bank of up to sixteen auxiliary event counters, and drives those bits out as per-counter enable lines. Software reaches the same state through two aliased 64-bit views. A one written through the set view turns the matching counter on. A one written through the clear view turns it off. A zero written through either view leaves the bit as it was. A read through either view returns the current enable pattern in the low sixteen bits, and every bit above those reads as zero.

The number of counters that respond is the smaller of the `LANES` parameter and the runtime `cnt_limit` input. Lanes at or above that count read as zero, ignore writes and keep their enable line low. When the counter-group count input is zero, the whole register is undefined: any access raises the undefined flag and changes nothing. A write made from below the highest privilege level is also flagged and dropped. Trapping for access permissions is decided elsewhere. Read data, the undefined flag and the enable lines are all registered.

Top module: `cen_regbank`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all enable lines, `rd_valid`, `rd_data` and `undef_o` are 0, and the stored enable state is all zero.
- R2: An accepted clear-view write (`wr_clr`) with a 1 in bit n below the effective count turns lane n off. A 0 in bit n leaves lane n unchanged.
- R3: An accepted set-view write (`wr_set`) with a 1 in bit n below the effective count turns lane n on. A 0 in bit n leaves lane n unchanged.
- R4: A defined read (`rd_req` with `grp_count` nonzero) raises `rd_valid` one cycle later, with `rd_data[15:0]` holding the enable state as it was before any write in the same cycle, and `rd_data[63:16]` equal to zero.
- R5: With effective count E = min(`cnt_limit`, `LANES`), lanes E and above read as 0, ignore writes through both views, and drive their enable line low.
- R6: When `grp_count` is 0, any read or write sets `undef_o` one cycle later, leaves `rd_valid` low and leaves the enable state unchanged.
- R7: A write with `priv_top` low sets `undef_o` one cycle later and is dropped. A read with `priv_top` low is still served.
- R8: If `wr_set` and `wr_clr` are both accepted in the same cycle, any lane whose data bit is 1 ends up disabled, because the clear wins.
- R9: `cnt_en` shows the enable state after an accepted write, masked by the effective count, exactly one cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read through either view |
| wr_set | input | 1 | Write through the set view |
| wr_clr | input | 1 | Write through the clear view |
| wr_data | input | 64 | Write data shared by both views |
| priv_top | input | 1 | Requester is at the highest privilege level |
| grp_count | input | 4 | Number of auxiliary counter groups; zero means absent |
| cnt_limit | input | 5 | Runtime count of implemented counters |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| undef_o | output | 1 | Undefined access seen in the previous cycle |
| cnt_en | output | 16 | Per-counter enable lines |

## Verification
Each result is due one cycle after the access that causes it. `rd_data` and `rd_valid` reflect the state as it was before that access. `cnt_en` reflects the state after it, and `undef_o` reflects how the access was classified. The bench drives an access on a falling edge and pushes the expected values for the next rising edge into a queue. The monitor samples one nanosecond after that rising edge and pops exactly one item for each edge, so every comparison lands in the cycle where its result is due. A reference model kept from the requirements supplies the expected enable state, including lanes above a lowered limit that keep their stored value while reading as zero.

// File: rtl/cen_pkg.sv
package cen_pkg;
  typedef struct packed {
    logic rd_ok;
    logic wr_set_ok;
    logic wr_clr_ok;
    logic undef;
  } gate_t;

  function automatic logic [15:0] apply_update(
      input logic [15:0] cur,
      input logic [15:0] set_m,
      input logic [15:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction
endpackage

// File: rtl/cen_lane_mask.sv
module cen_lane_mask #(
  parameter int LANES = 16,
  parameter int LIM_W = 5
) (
  input  logic [LIM_W-1:0] cnt_limit,
  output logic [LANES-1:0] lane_mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = (LIM_W'(i) < cnt_limit);
  end
endmodule

// File: rtl/cen_access_gate.sv
module cen_access_gate
  import cen_pkg::*;
#(
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             priv_top,
  input  logic [GRP_W-1:0] grp_count,
  output gate_t            gate,
  output logic             undef_q
);
  logic present;
  logic any_acc;
  logic any_wr;

  always_comb begin
    present        = (grp_count != '0);
    any_wr         = wr_set | wr_clr;
    any_acc        = rd_req | any_wr;
    gate.rd_ok     = present & rd_req;
    gate.wr_set_ok = present & priv_top & wr_set;
    gate.wr_clr_ok = present & priv_top & wr_clr;
    gate.undef     = (any_acc & ~present) | (present & any_wr & ~priv_top);
  end

  always_ff @(posedge clk) begin
    if (rst) undef_q <= 1'b0;
    else     undef_q <= gate.undef;
  end
endmodule

// File: rtl/cen_enable_core.sv
module cen_enable_core
  import cen_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  gate_t            gate,
  input  logic [LANES-1:0] wr_bits,
  input  logic [LANES-1:0] lane_mask,
  output logic [LANES-1:0] state_q,
  output logic [LANES-1:0] cnt_en_q
);
  logic [LANES-1:0] set_m;
  logic [LANES-1:0] clr_m;
  logic [LANES-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_bit
    assign set_m[i] = gate.wr_set_ok & wr_bits[i] & lane_mask[i];
    assign clr_m[i] = gate.wr_clr_ok & wr_bits[i] & lane_mask[i];
    assign nxt[i]   = (state_q[i] | set_m[i]) & ~clr_m[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= '0;
      cnt_en_q <= '0;
    end else begin
      state_q  <= nxt;
      cnt_en_q <= nxt & lane_mask;
    end
  end
endmodule

// File: rtl/cen_read_port.sv
module cen_read_port #(
  parameter int LANES = 16,
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_ok,
  input  logic [LANES-1:0] state_q,
  input  logic [LANES-1:0] lane_mask,
  output logic             rd_valid,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAD_W = REG_W - LANES;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_ok;
      if (rd_ok) rd_data <= {{PAD_W{1'b0}}, state_q & lane_mask};
      else       rd_data <= '0;
    end
  end
endmodule

// File: rtl/cen_regbank.sv
module cen_regbank
  import cen_pkg::*;
#(
  parameter int LANES = 16,
  parameter int REG_W = 64,
  parameter int GRP_W = 4,
  parameter int LIM_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             priv_top,
  input  logic [GRP_W-1:0] grp_count,
  input  logic [LIM_W-1:0] cnt_limit,
  output logic             rd_valid,
  output logic [REG_W-1:0] rd_data,
  output logic             undef_o,
  output logic [LANES-1:0] cnt_en
);
  gate_t            gate;
  logic [LANES-1:0] lane_mask;
  logic [LANES-1:0] state_q;

  cen_lane_mask #(.LANES(LANES), .LIM_W(LIM_W)) u_mask (
    .cnt_limit (cnt_limit),
    .lane_mask (lane_mask)
  );

  cen_access_gate #(.GRP_W(GRP_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .wr_set    (wr_set),
    .wr_clr    (wr_clr),
    .priv_top  (priv_top),
    .grp_count (grp_count),
    .gate      (gate),
    .undef_q   (undef_o)
  );

  cen_enable_core #(.LANES(LANES)) u_core (
    .clk       (clk),
    .rst       (rst),
    .gate      (gate),
    .wr_bits   (wr_data[LANES-1:0]),
    .lane_mask (lane_mask),
    .state_q   (state_q),
    .cnt_en_q  (cnt_en)
  );

  cen_read_port #(.LANES(LANES), .REG_W(REG_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_ok     (gate.rd_ok),
    .state_q   (state_q),
    .lane_mask (lane_mask),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/cen_regbank_chk.sv
module cen_regbank_chk #(
  parameter int LANES = 16,
  parameter int REG_W = 64,
  parameter int GRP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_req,
  input logic             wr_set,
  input logic             wr_clr,
  input logic [REG_W-1:0] wr_data,
  input logic             priv_top,
  input logic [GRP_W-1:0] grp_count,
  input logic [LANES-1:0] lane_mask,
  input logic             rd_valid,
  input logic [REG_W-1:0] rd_data,
  input logic             undef_o,
  input logic [LANES-1:0] cnt_en
);
  logic acc_any;
  logic ok;
  assign acc_any = rd_req | wr_set | wr_clr;
  assign ok      = (grp_count != '0) && priv_top;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_en == '0 && !rd_valid && !undef_o)); // R1

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    $past(wr_set && !wr_clr && ok) |->
      ((cnt_en & $past(wr_data[LANES-1:0] & lane_mask)) == $past(wr_data[LANES-1:0] & lane_mask))); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[REG_W-1:LANES] == '0)); // R4

  AST_LANE_INERT: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_data[LANES-1:0] & ~$past(lane_mask)) == '0)); // R5

  AST_NOGRP_UNDEF: assert property (@(posedge clk) disable iff (rst)
    $past(acc_any && grp_count == '0) |-> (undef_o && !rd_valid)); // R6

  AST_UNPRIV_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past((wr_set || wr_clr) && grp_count != '0 && !priv_top) |-> undef_o); // R7

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(wr_set && wr_clr && ok) |-> ((cnt_en & $past(wr_data[LANES-1:0])) == '0)); // R8
endmodule

bind cen_regbank cen_regbank_chk #(.LANES(LANES), .REG_W(REG_W), .GRP_W(GRP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_req    (rd_req),
  .wr_set    (wr_set),
  .wr_clr    (wr_clr),
  .wr_data   (wr_data),
  .priv_top  (priv_top),
  .grp_count (grp_count),
  .lane_mask (lane_mask),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .undef_o   (undef_o),
  .cnt_en    (cnt_en)
);

// File: tb/cen_regbank_tb.sv
module cen_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0, wr_set = 1'b0, wr_clr = 1'b0, priv_top = 1'b1;
  logic [63:0] wr_data = '0;
  logic [3:0]  grp_count = 4'd1;
  logic [4:0]  cnt_limit = 5'd16;
  logic        rd_valid, undef_o;
  logic [63:0] rd_data;
  logic [15:0] cnt_en;

  always #2 clk = ~clk;

  cen_regbank u_dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_data(wr_data), .priv_top(priv_top), .grp_count(grp_count),
    .cnt_limit(cnt_limit), .rd_valid(rd_valid), .rd_data(rd_data),
    .undef_o(undef_o), .cnt_en(cnt_en)
  );

  typedef struct {
    logic        vld;
    logic [63:0] data;
    logic        undef;
    logic [15:0] en;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  logic [15:0] m_state = '0;
  bit          done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic ws, input logic wc,
                      input logic [63:0] wd, input logic pt, input logic [3:0] grp,
                      input logic [4:0] lim, input string tag);
    exp_t        e;
    logic [15:0] mask, sm, cm;
    logic        pres;
    @(negedge clk);
    rd_req = rd; wr_set = ws; wr_clr = wc; wr_data = wd;
    priv_top = pt; grp_count = grp; cnt_limit = lim;
    mask = '0;
    for (int i = 0; i < 16; i++) if (i < int'(lim)) mask[i] = 1'b1;
    pres    = (grp != 0);
    e.tag   = tag;
    e.vld   = pres && rd;
    e.data  = e.vld ? {48'd0, m_state & mask} : 64'd0;
    e.undef = ((rd || ws || wc) && !pres) || (pres && (ws || wc) && !pt);
    sm = (pres && pt && ws) ? (wd[15:0] & mask) : 16'd0;
    cm = (pres && pt && wc) ? (wd[15:0] & mask) : 16'd0;
    m_state = (m_state | sm) & ~cm;
    e.en = m_state & mask;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 4'd1, cnt_limit, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " rd_valid"}, {63'd0, rd_valid}, {63'd0, e.vld});
        check({e.tag, " rd_data"}, rd_data, e.data);
        check({e.tag, " undef_o"}, {63'd0, undef_o}, {63'd0, e.undef});
        check({e.tag, " cnt_en R9"}, {48'd0, cnt_en}, {48'd0, e.en});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset cnt_en", {48'd0, cnt_en}, 64'd0);
    check("R1 reset rd_valid", {63'd0, rd_valid}, 64'd0);
    check("R1 reset undef", {63'd0, undef_o}, 64'd0);
    @(negedge clk); rst = 1'b0;
    idle("R1 after reset");
    step(1, 0, 0, 64'd0, 1, 1, 16, "R1 read zero");
    // R3 set view, upper data bits ignored
    step(0, 1, 0, 64'hFFFF_FFFF_0000_8421, 1, 1, 16, "R3 set");
    step(1, 0, 0, 64'd0, 1, 1, 16, "R4 read");
    step(0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 16, "R3 set all");
    step(1, 0, 0, 64'd0, 1, 1, 16, "R4 read upper zero");
    // R2 clear view
    step(0, 0, 1, 64'h0000_0000_0000_00F0, 1, 1, 16, "R2 clear");
    step(0, 0, 1, 64'd0, 1, 1, 16, "R2 clear zero");
    step(1, 1, 0, 64'h0000_0000_0000_0010, 1, 1, 16, "R4 read before write");
    step(1, 0, 0, 64'd0, 1, 1, 16, "R2 read");
    // R8 clear wins
    step(0, 1, 1, 64'h0000_0000_0000_0101, 1, 1, 16, "R8 both");
    step(0, 1, 1, 64'h0000_0000_0000_0060, 1, 1, 16, "R8 both set");
    step(1, 0, 0, 64'd0, 1, 1, 16, "R8 read");
    // R5 lanes above limit
    step(0, 0, 1, 64'h0000_0000_0000_FFFF, 1, 1, 16, "R5 clear all");
    step(0, 1, 0, 64'h0000_0000_0000_FFFF, 1, 1, 5, "R5 set limit 5");
    step(1, 0, 0, 64'd0, 1, 1, 5, "R5 read limit 5");
    step(1, 0, 0, 64'd0, 1, 1, 16, "R5 read limit 16");
    step(0, 1, 0, 64'h0000_0000_0000_F000, 1, 1, 16, "R5 set high");
    step(0, 0, 1, 64'h0000_0000_0000_FFFF, 1, 1, 12, "R5 clear limit 12");
    step(1, 0, 0, 64'd0, 1, 1, 16, "R5 high lanes kept");
    step(1, 0, 0, 64'd0, 1, 1, 0, "R5 limit 0");
    // R6 no counter group
    step(0, 1, 0, 64'h0000_0000_0000_00FF, 1, 0, 16, "R6 set nogrp");
    step(0, 0, 1, 64'h0000_0000_0000_F000, 1, 0, 16, "R6 clear nogrp");
    step(1, 0, 0, 64'd0, 1, 0, 16, "R6 read nogrp");
    step(1, 0, 0, 64'd0, 1, 1, 16, "R6 read after");
    // R7 unprivileged write dropped, read served
    step(0, 1, 0, 64'h0000_0000_0000_0F0F, 0, 1, 16, "R7 set unpriv");
    step(0, 0, 1, 64'h0000_0000_0000_F000, 0, 2, 16, "R7 clear unpriv");
    step(1, 0, 0, 64'd0, 0, 1, 16, "R7 read unpriv");
    idle("R9 drain");
    idle("R9 drain");
    wait (sb.size() == 0);
    @(posedge clk); #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule